// File: doc/BRIEF.md
# Event Counter with Glitch Filter

This block is a down-counting timer channel that decrements on one of two sources. In internal mode it counts single-cycle strobes from an on-chip prescaler. In event mode it counts edges of an external pin, and a polarity control selects whether rising or falling edges count. In event mode the internal prescaler strobe has no effect.

The pin is brought into the system clock domain through a two-stage synchronizer. An optional glitch filter can then sit in front of the edge detector. The filter acts only in event mode and only when its enable is set. It keeps an accepted level and adopts a new pin level only after that level has stayed in place across two falling edges of a slow reference. Each falling edge arrives as a one-cycle strobe, nominally at 2,048 Hz. With a 32.768 kHz base, this means pulses of 0.98 ms or longer are always counted and pulses of 0.48 ms or shorter are always rejected.

Software loads a start value through a load strobe, and the count advances only while the run control is high. When a step arrives at a count of one or zero, the channel reloads and raises a one-clock underflow pulse.

Top module: `evt_counter_top`

## Requirements
- R1: After reset, count_o is 0 and uf_o is 0.
- R2: A cycle with load_i high sets count_o to reload_i on the next clock edge, with priority over any count step.
- R3: With mode_i = 0 (internal mode), each int_tick_i strobe while run_i = 1 lowers count_o by one, and edges on ev_pin_i have no effect.
- R4: With mode_i = 1 (event mode), each qualifying pin edge while run_i = 1 lowers count_o by one, and int_tick_i has no effect.
- R5: pol_i = 1 makes a rising pin edge the counting edge. pol_i = 0 makes a falling edge the counting edge. The other edge never counts.
- R6: While run_i = 0, count_o holds its value unless load_i is high.
- R7: With mode_i = 1 and filt_en_i = 1, a pin level that returns to the accepted level before two ref_tick_i strobes have been seen is dropped and produces no count.
- R8: With mode_i = 1 and filt_en_i = 1, a pin level held for at least two full reference periods is accepted on the second ref_tick_i strobe after the synchronized change. Its edge is then counted once.
- R9: A count step taken when count_o is 1 or 0 loads reload_i instead of decrementing and raises uf_o for exactly that one following cycle.
- R10: ev_pin_i passes through two synchronizer flops. With the filter off, a pin edge set up before clock edge A changes count_o at clock edge A+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | One-cycle strobe marking each falling edge of the slow filter reference |
| int_tick_i | input | 1 | One-cycle strobe from the internal prescaler |
| ev_pin_i | input | 1 | Asynchronous external event pin |
| mode_i | input | 1 | 0 selects internal counting, 1 selects event counting |
| pol_i | input | 1 | Counting edge: 1 rising, 0 falling |
| filt_en_i | input | 1 | Enables the glitch filter in event mode |
| run_i | input | 1 | Counting enable |
| load_i | input | 1 | Loads reload_i into the counter |
| reload_i | input | CNT_W | Start and reload value |
| count_o | output | CNT_W | Current count |
| uf_o | output | 1 | One-cycle underflow pulse |

## Verification
The assertions assume that ref_tick_i and int_tick_i are single-cycle strobes and that the control inputs change only between stimulus phases, never in the middle of a pulse being filtered. The bench generates the reference strobe from a free-running divider with a 16-cycle period. It keeps every pulse it drives either clearly shorter than one reference period or clearly longer than two, so each pulse has only one possible outcome. Control bits are changed only after the pin has been idle long enough for the synchronizer, the filter and the edge detector to settle.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int PASS_TICKS  = 2;
    localparam int PASS_W      = $clog2(PASS_TICKS + 1);

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EVENT    = 1'b1
    } src_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;

    typedef struct packed {
        src_e  src;
        edge_e edge_sel;
        logic  filt_en;
        logic  run;
    } ctrl_t;

    function automatic logic pick_edge(edge_e sel, logic cur, logic prev);
        return (sel == EDGE_RISE) ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic pick_step(src_e src, logic int_tick, logic ev_step);
        return (src == SRC_EVENT) ? ev_step : int_tick;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_glitch_filter.sv
module evt_glitch_filter
    import evt_counter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic ref_tick_i,
    input  logic sync_i,
    output logic lvl_o
);
    logic              acc_q;
    logic [PASS_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= 1'b0;
            seen_q <= '0;
        end else if (!en_i) begin
            acc_q  <= sync_i;
            seen_q <= '0;
        end else if (sync_i == acc_q) begin
            seen_q <= '0;
        end else if (ref_tick_i) begin
            if (seen_q == PASS_W'(PASS_TICKS - 1)) begin
                acc_q  <= sync_i;
                seen_q <= '0;
            end else begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    assign lvl_o = en_i ? acc_q : sync_i;

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && !ref_tick_i) |=> $stable(acc_q));

    assert_pending_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && (sync_i == acc_q)) |=> (seen_q == '0));

    assert_accept_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && (acc_q != $past(acc_q))) |-> $past(ref_tick_i));
endmodule

// File: rtl/evt_edge_sel.sv
module evt_edge_sel
    import evt_counter_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_e edge_sel_i,
    input  logic  lvl_i,
    output logic  step_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign step_o = pick_edge(edge_sel_i, lvl_i, prev_q);

    assert_one_cycle_step_R5: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             uf_o
);
    logic [CNT_W-1:0] count_q;
    logic             uf_q;
    logic             adv;
    logic             at_end;

    assign adv    = run_i & step_i & ~load_i;
    assign at_end = (count_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            uf_q    <= 1'b0;
        end else begin
            uf_q <= 1'b0;
            if (load_i) begin
                count_q <= reload_i;
            end else if (adv) begin
                if (at_end) begin
                    count_q <= reload_i;
                    uf_q    <= 1'b1;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end

    assign count_o = count_q;
    assign uf_o    = uf_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_q == $past(reload_i)));

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_i) |=> $stable(count_q));

    assert_dec_one_R4: assert property (@(posedge clk) disable iff (rst)
        (run_i && step_i && !load_i && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - 1'b1));

    assert_uf_reload_R9: assert property (@(posedge clk) disable iff (rst)
        uf_q |-> (count_q == $past(reload_i)));
endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
    import evt_counter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick_i,
    input  logic             int_tick_i,
    input  logic             ev_pin_i,
    input  logic             mode_i,
    input  logic             pol_i,
    input  logic             filt_en_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             uf_o
);
    ctrl_t ctrl;
    logic  pin_sync;
    logic  pin_lvl;
    logic  ev_step;
    logic  step;

    assign ctrl.src      = src_e'(mode_i);
    assign ctrl.edge_sel = edge_e'(pol_i);
    assign ctrl.filt_en  = filt_en_i;
    assign ctrl.run      = run_i;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ev_pin_i),
        .q_o (pin_sync)
    );

    evt_glitch_filter u_filt (
        .clk        (clk),
        .rst        (rst),
        .en_i       ((ctrl.src == SRC_EVENT) && ctrl.filt_en),
        .ref_tick_i (ref_tick_i),
        .sync_i     (pin_sync),
        .lvl_o      (pin_lvl)
    );

    evt_edge_sel u_edge (
        .clk        (clk),
        .rst        (rst),
        .edge_sel_i (ctrl.edge_sel),
        .lvl_i      (pin_lvl),
        .step_o     (ev_step)
    );

    assign step = pick_step(ctrl.src, int_tick_i, ev_step);

    evt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_i    (ctrl.run),
        .step_i   (step),
        .load_i   (load_i),
        .reload_i (reload_i),
        .count_o  (count_o),
        .uf_o     (uf_o)
    );

    assert_internal_ignores_pin_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !int_tick_i && !load_i) |=> $stable(count_o));

    assert_event_ignores_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !ev_step && !load_i) |=> $stable(count_o));
endmodule

// File: tb/sim_evt_counter_top.sv
`timescale 1ns/1ps
module sim_evt_counter_top;
    localparam int W   = 16;
    localparam int REF = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0, int_tick = 1'b0, pin = 1'b0;
    logic mode = 1'b0, pol = 1'b0, filt = 1'b0, run = 1'b0, load = 1'b0;
    logic [W-1:0] reload = '0;
    logic [W-1:0] count;
    logic uf;

    int total = 0;
    int bad = 0;
    int uf_seen = 0;
    int refdiv = 0;
    logic [W-1:0] exp_c;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    evt_counter_top #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .ref_tick_i(ref_tick), .int_tick_i(int_tick),
        .ev_pin_i(pin), .mode_i(mode), .pol_i(pol), .filt_en_i(filt),
        .run_i(run), .load_i(load), .reload_i(reload),
        .count_o(count), .uf_o(uf)
    );

    always @(negedge clk) begin
        refdiv   = (refdiv == REF - 1) ? 0 : refdiv + 1;
        ref_tick = (refdiv == 0);
    end

    always @(posedge clk) if (!rst && uf) uf_seen++;

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] v);
        reload = v; load = 1'b1; waitn(1); load = 1'b0; waitn(1);
    endtask

    task automatic tick_int;
        int_tick = 1'b1; waitn(1); int_tick = 1'b0; waitn(1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        waitn(3);
        // R1: reset state
        chk("R1 count", count, '0);
        chk("R1 uf", {15'd0, uf}, '0);
        rst = 1'b0;
        waitn(2);

        // R9: a step at count 0 reloads and pulses uf
        reload = 16'd5; run = 1'b1; uf_seen = 0;
        tick_int();
        chk("R9 reload from zero", count, 16'd5);
        chk("R9 uf pulse", W'(uf_seen), 16'd1);

        // R2: load
        do_load(16'd200);
        chk("R2 load", count, 16'd200);

        // R3: internal mode, sweep of tick counts, pin ignored
        exp_c = 16'd200;
        for (int n = 1; n <= 6; n++) begin
            for (int k = 0; k < n; k++) begin
                tick_int();
                pin = ~pin; waitn(4);
            end
            exp_c = exp_c - W'(n);
            chk("R3 internal count", count, exp_c);
        end
        pin = 1'b0; waitn(6);
        chk("R3 pin ignored", count, exp_c);

        // R6: run low holds
        run = 1'b0;
        for (int k = 0; k < 4; k++) tick_int();
        chk("R6 stopped", count, exp_c);
        run = 1'b1;

        // R4/R5/R10: event mode, no filter, rising
        mode = 1'b1; pol = 1'b1; filt = 1'b0; waitn(6);
        do_load(16'd100); exp_c = 16'd100;
        for (int k = 0; k < 4; k++) tick_int();
        chk("R4 int tick ignored", count, exp_c);
        // R10: latency
        @(negedge clk); pin = 1'b1;
        waitn(2);
        chk("R10 not yet", count, exp_c);
        waitn(1);
        exp_c = exp_c - 1;
        chk("R10 counted at third edge", count, exp_c);
        waitn(3);
        pin = 1'b0; waitn(6);
        chk("R5 falling ignored when rising", count, exp_c);
        for (int w = 1; w <= 6; w++) begin
            pin = 1'b1; waitn(w); pin = 1'b0; waitn(6);
            exp_c = exp_c - 1;
            chk("R4 width sweep rising", count, exp_c);
        end

        // R5: falling polarity
        pol = 1'b0; waitn(4);
        pin = 1'b1; waitn(6);
        chk("R5 rising ignored when falling", count, exp_c);
        pin = 1'b0; waitn(6);
        exp_c = exp_c - 1;
        chk("R5 falling counted", count, exp_c);

        // R7/R8: filter on, rising polarity
        pol = 1'b1; filt = 1'b1; waitn(8);
        do_load(16'd80); exp_c = 16'd80;
        for (int w = 1; w <= 14; w++) begin
            pin = 1'b1; waitn(w); pin = 1'b0; waitn(60);
            chk("R7 glitch rejected", count, exp_c);
        end
        for (int w = 34; w <= 40; w++) begin
            pin = 1'b1; waitn(w); pin = 1'b0; waitn(60);
            exp_c = exp_c - 1;
            chk("R8 long pulse accepted", count, exp_c);
        end
        // R7: low glitches inside a long high level
        pin = 1'b1; waitn(50);
        exp_c = exp_c - 1;
        for (int w = 1; w <= 10; w++) begin
            pin = 1'b0; waitn(w); pin = 1'b1; waitn(40);
        end
        chk("R7 low glitches rejected", count, exp_c);
        pin = 1'b0; waitn(60);

        // R9: underflow chain in event mode
        filt = 1'b0; waitn(4);
        reload = 16'd3; do_load(16'd3); uf_seen = 0;
        for (int k = 0; k < 3; k++) begin
            pin = 1'b1; waitn(4); pin = 1'b0; waitn(4);
        end
        chk("R9 reloaded after underflow", count, 16'd3);
        chk("R9 single uf", W'(uf_seen), 16'd1);

        finish_run();
    end
endmodule